// File: doc/BRIEF.md
# TPM FIFO Command Sequencer

This block runs one complete command exchange with a TPM-style security device that is reached through register reads and writes. A SPI transaction framer beside it carries each register access on the wire; this block only decides which register to touch, in which direction and with how many bytes, and it streams the data bytes to or from that framer. The command comes from a local byte buffer and the response goes to a second local byte buffer. The sequencer checks the length that the command declares about itself. It announces the command to the device and pushes the command into the device FIFO in chunks that the device can accept. It then starts execution, polls for the result on a prescaled millisecond timer and drains the response. Finally it checks the end-of-data handshake and returns the device to idle.

A host loads the command buffer, drives `cmd_len` and `rsp_cap`, and pulses `start`. Some cycles later `done` pulses for one cycle with either `err` = 0 and the response length on `rsp_len`, or a nonzero `err` that names the step that failed. `start` is taken only while the block is idle. `cmd_len` and `rsp_cap` are captured at `start`.

Framer contract: `fr_req` rises with `fr_write`, `fr_addr` and `fr_len` (1 to 64 bytes) valid and holds them steady. The framer takes one write byte per `fr_tx_pop` or delivers one read byte per `fr_rx_valid`. It pulses `fr_end` in a cycle after the last data byte. `fr_req` falls in the cycle after `fr_end`. The status register is transferred as four bytes, least significant byte first. The command buffer read is combinational.

Top module: `tpm_fifo_seq`

## Requirements
- R1: After reset and between runs, `busy`, `done` and `fr_req` are 0. `done` is a single-cycle pulse, and `busy` is 0 in that cycle.
- R2: A command whose `cmd_len` is below 6, or whose big-endian 32-bit size field (command bytes 2 to 5) differs from `cmd_len`, ends with `err` = 1 and no framer transaction.
- R3: The first transaction of an accepted command is a 4-byte write to the status address (0xD40018) with bytes 0x40, 0x00, 0x00, 0x00 (command-ready is status bit 6).
- R4: Every FIFO chunk, except the 6-byte header read and the final 1-byte read, is preceded by a 4-byte status read whose burst field (status bits 23:8, that is bytes 1 and 2) is nonzero. A zero burst makes the sequencer read status again.
- R5: Each chunk length is the minimum of the bytes still to move, the last burst value and 64. Command bytes go to the FIFO address (0xD40024) in buffer order.
- R6: Once all command bytes are sent, a 4-byte status write of 0x20, 0x00, 0x00, 0x00 (go is bit 5) follows.
- R7: After go, the sequencer waits TICK_CYCLES cycles before each status read. It stops polling when status-valid (bit 7) and data-available (bit 4) are both 1. After POLL_LIMIT polls without success, it ends with `err` = 2.
- R8: The response starts with a 6-byte FIFO read whose big-endian size field is bytes 2 to 5. A size above `rsp_cap` or below 7 ends with `err` = 3.
- R9: Response bytes 6 up to size-2 are read in chunks as in R4 and R5. A status read must then show bits 7 and 4 both set, or the run ends with `err` = 4.
- R10: The last response byte is read alone with a 1-byte FIFO read and stored at offset size-1. A following status read must show bit 7 set and bit 4 clear, or the run ends with `err` = 5.
- R11: On success, a status write of 0x40, 0x00, 0x00, 0x00 is issued, and then `done` pulses with `err` = 0 and `rsp_len` equal to the response size.
- R12: Each response byte is written at its own offset in the response, and `rsp_we` is never 1 for an offset at or above the captured `rsp_cap`.
- R13: `fr_req` stays 1 with steady `fr_write`, `fr_addr` and `fr_len` until `fr_end`, and is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one command exchange (taken when idle) |
| cmd_len | input | LEN_W | Command length in bytes |
| rsp_cap | input | LEN_W | Response buffer capacity in bytes |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Result code: 0 ok, 1 command size, 2 timeout, 3 response size, 4 mid status, 5 end status |
| rsp_len | output | LEN_W | Response length on success |
| cmd_addr | output | LEN_W | Command buffer read offset |
| cmd_data | input | 8 | Command buffer byte at `cmd_addr` |
| rsp_we | output | 1 | Response buffer write enable |
| rsp_addr | output | LEN_W | Response buffer write offset |
| rsp_wdata | output | 8 | Response buffer write byte |
| fr_req | output | 1 | Transaction request to the framer |
| fr_write | output | 1 | 1 for register write, 0 for read |
| fr_addr | output | ADDR_W | Register address |
| fr_len | output | 7 | Byte count, 1 to 64 |
| fr_tx_data | output | 8 | Current write byte |
| fr_tx_pop | input | 1 | Framer consumed the write byte |
| fr_rx_valid | input | 1 | Framer delivers a read byte |
| fr_rx_data | input | 8 | Read byte |
| fr_end | input | 1 | Transaction complete |

## Verification
A wrong byte position or remaining-count register shows up at once at the framer port. The next chunk carries a length other than min(remaining, burst, 64), or a stray 1-byte read appears before the expected header or chunk. So the fault is visible in the transaction that follows the corrupted step. A bad response pointer shows up in the buffer contents or as a write at an offset at or above the capacity, in the same cycle as the offending byte. A wrong step in the handshake order shows as a misplaced status write value or as a wrong error code on `done`. The poll counter is checked by the exact number of status reads seen before a timeout is declared.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_CMD_SIZE = 3'd1,
    ERR_TIMEOUT  = 3'd2,
    ERR_RSP_SIZE = 3'd3,
    ERR_MID_STS  = 3'd4,
    ERR_END_STS  = 3'd5
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_WR_RDY, S_TX_BURST, S_TX_CHUNK, S_WR_GO,
    S_POLL_WAIT, S_POLL_RD, S_HDR, S_RX_BURST, S_RX_CHUNK,
    S_MID, S_LAST, S_FIN, S_WR_IDLE
  } seq_state_e;

  localparam int STS_VALID_BIT = 7;
  localparam int STS_READY_BIT = 6;
  localparam int STS_GO_BIT    = 5;
  localparam int STS_AVAIL_BIT = 4;
  localparam int HDR_BYTES     = 6;
  localparam int MAX_CHUNK     = 64;
  localparam logic [7:0] READY_BYTE = 8'(1 << STS_READY_BIT);
  localparam logic [7:0] GO_BYTE    = 8'(1 << STS_GO_BIT);

  // Burst count field of a status word
  function automatic logic [15:0] burst_of(input logic [31:0] s);
    return s[23:8];
  endfunction

  // Chunk = min(remaining, burst, MAX_CHUNK)
  function automatic logic [6:0] chunk_size(input logic [31:0] remaining,
                                            input logic [15:0] burst);
    logic [31:0] m;
    m = remaining;
    if ({16'b0, burst} < m) m = {16'b0, burst};
    if (32'(MAX_CHUNK) < m) m = 32'(MAX_CHUNK);
    return m[6:0];
  endfunction

  // Accumulate a big-endian field one byte at a time
  function automatic logic [31:0] be_shift(input logic [31:0] acc,
                                           input logic [7:0] b);
    return {acc[23:0], b};
  endfunction

  function automatic logic has_response(input logic [7:0] s);
    return s[STS_VALID_BIT] & s[STS_AVAIL_BIT];
  endfunction

  function automatic logic drained(input logic [7:0] s);
    return s[STS_VALID_BIT] & ~s[STS_AVAIL_BIT];
  endfunction

  function automatic logic size_bad(input logic [31:0] size,
                                    input logic [31:0] cap);
    return (size > cap) || (size < 32'(HDR_BYTES + 1));
  endfunction

endpackage

// File: rtl/tfs_xact.sv
module tfs_xact #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [6:0]        len,
  output logic              idle,
  output logic              xdone,
  output logic              rx_stb,
  output logic [6:0]        idx,
  output logic [31:0]       word,
  output logic              fr_req,
  output logic              fr_write,
  output logic [ADDR_W-1:0] fr_addr,
  output logic [6:0]        fr_len,
  input  logic              fr_tx_pop,
  input  logic              fr_rx_valid,
  input  logic [7:0]        fr_rx_data,
  input  logic              fr_end
);
  logic busy_q;
  logic byte_evt;

  assign byte_evt = busy_q & ((fr_write & fr_tx_pop) | (~fr_write & fr_rx_valid));
  assign rx_stb   = busy_q & ~fr_write & fr_rx_valid;
  assign xdone    = busy_q & fr_end;
  assign idle     = ~busy_q;
  assign fr_req   = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      fr_write <= 1'b0;
      fr_addr  <= '0;
      fr_len   <= 7'd0;
      idx      <= 7'd0;
      word     <= 32'd0;
    end else if (!busy_q) begin
      if (go) begin
        busy_q   <= 1'b1;
        fr_write <= wr;
        fr_addr  <= addr;
        fr_len   <= len;
        idx      <= 7'd0;
        word     <= 32'd0;
      end
    end else if (fr_end) begin
      busy_q <= 1'b0;
    end else if (byte_evt) begin
      idx <= idx + 7'd1;
      if (rx_stb) begin
        case (idx[1:0])
          2'd0: word[7:0]   <= fr_rx_data;
          2'd1: word[15:8]  <= fr_rx_data;
          2'd2: word[23:16] <= fr_rx_data;
          default: word[31:24] <= fr_rx_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/tfs_timer.sv
module tfs_timer #(
  parameter int TICK_CYCLES = 125000,
  parameter int POLL_LIMIT  = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick,
  output logic expired
);
  localparam int CW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] polls_q;

  assign tick    = run && (cnt_q == CW'(TICK_CYCLES - 1));
  assign expired = (polls_q == PW'(POLL_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q   <= '0;
      polls_q <= '0;
    end else if (run) begin
      if (tick) begin
        cnt_q <= '0;
        if (!expired) polls_q <= polls_q + PW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/tpm_fifo_seq.sv
module tpm_fifo_seq
  import tfs_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 24'hD40018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 24'hD40024,
  parameter int TICK_CYCLES = 125000,
  parameter int POLL_LIMIT  = 120000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [LEN_W-1:0]  rsp_cap,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [LEN_W-1:0]  cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              rsp_we,
  output logic [LEN_W-1:0]  rsp_addr,
  output logic [7:0]        rsp_wdata,
  output logic              fr_req,
  output logic              fr_write,
  output logic [ADDR_W-1:0] fr_addr,
  output logic [6:0]        fr_len,
  output logic [7:0]        fr_tx_data,
  input  logic              fr_tx_pop,
  input  logic              fr_rx_valid,
  input  logic [7:0]        fr_rx_data,
  input  logic              fr_end
);
  seq_state_e        state;
  logic [LEN_W-1:0]  len_q, cap_q;
  logic [31:0]       acc_q, size_q, hand_q;
  logic [2:0]        chk_cnt;
  logic [6:0]        chunk_q;

  // Transaction engine request and events
  logic              x_go, x_wr, x_idle, x_done, x_rx_stb, x_uses;
  logic [ADDR_W-1:0] x_addr;
  logic [6:0]        x_len, x_idx;
  logic [31:0]       x_word;

  // Timer events
  logic tick, expired, tmr_clear, tmr_run;

  // Named internal events
  logic [31:0] buf_pos;
  logic [15:0] live_burst;
  logic        rsp_phase;
  logic [31:0] cmd_left, rsp_left;
  logic [31:0] cap_ext, len_ext;

  assign live_burst = burst_of(x_word);
  assign buf_pos    = hand_q + 32'(x_idx);
  assign cap_ext    = 32'(cap_q);
  assign len_ext    = 32'(len_q);
  assign cmd_left   = len_ext - hand_q;
  assign rsp_left   = size_q - 32'd1 - hand_q;
  assign rsp_phase  = (state == S_HDR) || (state == S_RX_CHUNK) || (state == S_LAST);

  tfs_xact #(.ADDR_W(ADDR_W)) u_xact (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (x_go),
    .wr         (x_wr),
    .addr       (x_addr),
    .len        (x_len),
    .idle       (x_idle),
    .xdone      (x_done),
    .rx_stb     (x_rx_stb),
    .idx        (x_idx),
    .word       (x_word),
    .fr_req     (fr_req),
    .fr_write   (fr_write),
    .fr_addr    (fr_addr),
    .fr_len     (fr_len),
    .fr_tx_pop  (fr_tx_pop),
    .fr_rx_valid(fr_rx_valid),
    .fr_rx_data (fr_rx_data),
    .fr_end     (fr_end)
  );

  assign tmr_clear = (state == S_WR_GO);
  assign tmr_run   = (state == S_POLL_WAIT);

  tfs_timer #(.TICK_CYCLES(TICK_CYCLES), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_clear),
    .run    (tmr_run),
    .tick   (tick),
    .expired(expired)
  );

  // Which register access each state needs
  always_comb begin
    x_uses     = 1'b1;
    x_wr       = 1'b0;
    x_addr     = STS_ADDR;
    x_len      = 7'd4;
    fr_tx_data = 8'h00;
    unique case (state)
      S_WR_RDY, S_WR_IDLE: begin
        x_wr = 1'b1;
        fr_tx_data = (x_idx == 7'd0) ? READY_BYTE : 8'h00;
      end
      S_WR_GO: begin
        x_wr = 1'b1;
        fr_tx_data = (x_idx == 7'd0) ? GO_BYTE : 8'h00;
      end
      S_TX_BURST, S_POLL_RD, S_RX_BURST, S_MID, S_FIN: x_uses = 1'b1;
      S_TX_CHUNK: begin
        x_wr = 1'b1;
        x_addr = FIFO_ADDR;
        x_len = chunk_q;
        fr_tx_data = cmd_data;
      end
      S_HDR: begin
        x_addr = FIFO_ADDR;
        x_len = 7'(HDR_BYTES);
      end
      S_RX_CHUNK: begin
        x_addr = FIFO_ADDR;
        x_len = chunk_q;
      end
      S_LAST: begin
        x_addr = FIFO_ADDR;
        x_len = 7'd1;
      end
      default: x_uses = 1'b0;
    endcase
  end

  assign x_go = x_uses && x_idle;

  assign cmd_addr  = (state == S_CHK) ? LEN_W'(32'd2 + 32'(chk_cnt))
                                      : buf_pos[LEN_W-1:0];
  assign rsp_addr  = buf_pos[LEN_W-1:0];
  assign rsp_wdata = fr_rx_data;
  assign rsp_we    = x_rx_stb && rsp_phase && (buf_pos < cap_ext);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      len_q   <= '0;
      cap_q   <= '0;
      acc_q   <= 32'd0;
      size_q  <= 32'd0;
      hand_q  <= 32'd0;
      chk_cnt <= 3'd0;
      chunk_q <= 7'd0;
      done    <= 1'b0;
      err     <= ERR_NONE;
      rsp_len <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_HDR && x_rx_stb && x_idx >= 7'd2 && x_idx <= 7'd5)
        size_q <= be_shift(size_q, fr_rx_data);
      unique case (state)
        S_IDLE: if (start) begin
          len_q   <= cmd_len;
          cap_q   <= rsp_cap;
          err     <= ERR_NONE;
          rsp_len <= '0;
          acc_q   <= 32'd0;
          chk_cnt <= 3'd0;
          hand_q  <= 32'd0;
          if (32'(cmd_len) < 32'(HDR_BYTES)) begin
            done <= 1'b1;
            err  <= ERR_CMD_SIZE;
          end else begin
            state <= S_CHK;
          end
        end
        S_CHK: begin
          if (chk_cnt != 3'd4) begin
            acc_q   <= be_shift(acc_q, cmd_data);
            chk_cnt <= chk_cnt + 3'd1;
          end else if (acc_q == len_ext) begin
            state <= S_WR_RDY;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= ERR_CMD_SIZE;
          end
        end
        S_WR_RDY: if (x_done) state <= S_TX_BURST;
        S_TX_BURST: if (x_done && live_burst != 16'd0) begin
          chunk_q <= chunk_size(cmd_left, live_burst);
          state   <= S_TX_CHUNK;
        end
        S_TX_CHUNK: if (x_done) begin
          hand_q <= hand_q + 32'(chunk_q);
          state  <= (hand_q + 32'(chunk_q) == len_ext) ? S_WR_GO : S_TX_BURST;
        end
        S_WR_GO: if (x_done) state <= S_POLL_WAIT;
        S_POLL_WAIT: if (tick) begin
          if (expired) begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= ERR_TIMEOUT;
          end else begin
            state <= S_POLL_RD;
          end
        end
        S_POLL_RD: if (x_done) begin
          if (has_response(x_word[7:0])) begin
            state  <= S_HDR;
            hand_q <= 32'd0;
            size_q <= 32'd0;
          end else begin
            state <= S_POLL_WAIT;
          end
        end
        S_HDR: if (x_done) begin
          if (size_bad(size_q, cap_ext)) begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= ERR_RSP_SIZE;
          end else begin
            hand_q <= 32'(HDR_BYTES);
            state  <= (size_q == 32'(HDR_BYTES + 1)) ? S_MID : S_RX_BURST;
          end
        end
        S_RX_BURST: if (x_done && live_burst != 16'd0) begin
          chunk_q <= chunk_size(rsp_left, live_burst);
          state   <= S_RX_CHUNK;
        end
        S_RX_CHUNK: if (x_done) begin
          hand_q <= hand_q + 32'(chunk_q);
          state  <= (hand_q + 32'(chunk_q) == size_q - 32'd1) ? S_MID : S_RX_BURST;
        end
        S_MID: if (x_done) begin
          if (has_response(x_word[7:0])) begin
            state <= S_LAST;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= ERR_MID_STS;
          end
        end
        S_LAST: if (x_done) state <= S_FIN;
        S_FIN: if (x_done) begin
          if (drained(x_word[7:0])) begin
            state <= S_WR_IDLE;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= ERR_END_STS;
          end
        end
        S_WR_IDLE: if (x_done) begin
          state   <= S_IDLE;
          done    <= 1'b1;
          err     <= ERR_NONE;
          rsp_len <= size_q[LEN_W-1:0];
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpm_fifo_seq_chk.sv
module tpm_fifo_seq_chk #(
  parameter int LEN_W = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [2:0]        err,
  input logic [LEN_W-1:0]  rsp_len,
  input logic              rsp_we,
  input logic [LEN_W-1:0]  rsp_addr,
  input logic [LEN_W-1:0]  cap_q,
  input logic              fr_req,
  input logic              fr_write,
  input logic [ADDR_W-1:0] fr_addr,
  input logic [6:0]        fr_len,
  input logic              fr_end
);
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |-> (rsp_addr < cap_q));

  a_r5_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fr_req |-> (fr_len != 7'd0 && fr_len <= 7'd64));

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_req && !fr_end) |=> (fr_req && $stable(fr_addr) && $stable(fr_len) && $stable(fr_write)));

  a_r13_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_req && fr_end) |=> !fr_req);

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !fr_req));

  a_r11_ok_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 3'd0) |-> (rsp_len >= LEN_W'(7)));
endmodule

bind tpm_fifo_seq tpm_fifo_seq_chk #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .rsp_len (rsp_len),
  .rsp_we  (rsp_we),
  .rsp_addr(rsp_addr),
  .cap_q   (cap_q),
  .fr_req  (fr_req),
  .fr_write(fr_write),
  .fr_addr (fr_addr),
  .fr_len  (fr_len),
  .fr_end  (fr_end)
);

// File: tb/tb_tpm_fifo_seq.sv
module tb_tpm_fifo_seq;
  localparam int TICK = 6;
  localparam int PLIM = 5;
  localparam logic [23:0] STS  = 24'hD40018;
  localparam logic [23:0] FIFO = 24'hD40024;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] cmd_len = 0, rsp_cap = 0;
  logic busy, done, rsp_we, fr_req, fr_write;
  logic [2:0] err;
  logic [15:0] rsp_len, cmd_addr, rsp_addr;
  logic [7:0] cmd_data, rsp_wdata, fr_tx_data;
  logic [23:0] fr_addr;
  logic [6:0] fr_len;
  logic fr_tx_pop = 0, fr_rx_valid = 0, fr_end = 0;
  logic [7:0] fr_rx_data = 0;

  always #4 clk = ~clk;

  logic [7:0] cmd_mem [0:255];
  logic [7:0] rsp_mem [0:255];
  logic [7:0] dev_rsp [0:255];
  assign cmd_data = cmd_mem[cmd_addr[7:0]];

  tpm_fifo_seq #(.TICK_CYCLES(TICK), .POLL_LIMIT(PLIM)) dut (.*);

  int nchk = 0, nfail = 0;
  // device model
  int dev_size, rd_ptr, poll_cnt, avail_after, def_burst;
  bit go_seen, stuck_avail, mid_bad;
  int burst_q[$];
  // reference tracking
  int tx_sent, rx_got, last_burst, trans_n, sts_after_go, cur_cap;
  bit hdr_done, burst_ok;
  int wr_log[$], tx_chunks[$], rx_chunks[$];
  // framer model
  bit in_x, x_wr, done_seen;
  int x_len, bi, got_err, got_len;
  logic [23:0] x_addr;
  logic [31:0] x_sts;
  logic [7:0] wbytes [0:63];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int min3(input int a, input int b, input int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  task automatic start_trans();
    trans_n++;
    if (x_addr == STS && !x_wr) begin
      int b;
      bit av;
      b = (burst_q.size() > 0) ? burst_q.pop_front() : def_burst;
      av = go_seen && poll_cnt >= avail_after && (rd_ptr < dev_size || stuck_avail)
           && !(mid_bad && rd_ptr == dev_size - 1);
      x_sts = {8'h00, b[15:0], 8'h80 | (av ? 8'h10 : 8'h00)};
      last_burst = b;
      if (b != 0) burst_ok = 1;
      if (go_seen) begin poll_cnt++; sts_after_go++; end
    end else if (x_addr == FIFO && x_wr) begin
      // R4 / R5: chunk follows a nonzero burst read and is min-sized
      chk(burst_ok, "R4", "status read before command chunk", burst_ok, 1);
      chk(x_len == min3(cmd_len - tx_sent, last_burst, 64), "R5", "tx chunk length",
          x_len, min3(cmd_len - tx_sent, last_burst, 64));
      burst_ok = 0;
      tx_chunks.push_back(x_len);
    end else if (x_addr == FIFO) begin
      rx_chunks.push_back(x_len);
      if (hdr_done && rx_got < dev_size - 1) begin
        chk(burst_ok, "R9", "status read before response chunk", burst_ok, 1);
        chk(x_len == min3(dev_size - 1 - rx_got, last_burst, 64), "R9", "rx chunk length",
            x_len, min3(dev_size - 1 - rx_got, last_burst, 64));
        burst_ok = 0;
      end
    end
  endtask

  task automatic finish_trans();
    if (trans_n == 1)
      chk(x_wr && x_addr == STS, "R3", "first transaction is status write", x_addr, STS);
    if (x_addr == STS && x_wr) begin
      int v;
      v = {wbytes[3], wbytes[2], wbytes[1], wbytes[0]};
      wr_log.push_back(v);
      if (v == 32'h20) begin go_seen = 1; poll_cnt = 0; end
    end else if (x_addr == FIFO && x_wr) begin
      int bad = 0;
      for (int i = 0; i < x_len; i++)
        if (wbytes[i] != cmd_mem[tx_sent + i]) bad++;
      chk(bad == 0, "R5", "command byte order", bad, 0);
      tx_sent += x_len;
    end else if (x_addr == FIFO) begin
      rd_ptr += x_len;
      if (!hdr_done) begin hdr_done = 1; rx_got = 6; end
      else rx_got += x_len;
    end
  endtask

  // framer and device model, one step per falling edge
  initial begin
    in_x = 0;
    forever begin
      @(negedge clk);
      fr_tx_pop = 0; fr_rx_valid = 0; fr_end = 0;
      if (in_x) begin
        if (bi < x_len) begin
          if (x_wr) begin fr_tx_pop = 1; wbytes[bi] = fr_tx_data; end
          else begin
            fr_rx_valid = 1;
            fr_rx_data = (x_addr == STS) ? x_sts[8*(bi%4) +: 8] : dev_rsp[(rd_ptr + bi) % 256];
          end
          bi++;
        end else begin
          fr_end = 1; in_x = 0; finish_trans();
        end
      end else if (fr_req) begin
        in_x = 1; bi = 0; x_wr = fr_write; x_addr = fr_addr; x_len = fr_len;
        start_trans();
      end
      #1;
      if (rsp_we) begin
        chk(rsp_addr < cur_cap, "R12", "write below capacity", rsp_addr, cur_cap);
        rsp_mem[rsp_addr[7:0]] = rsp_wdata;
      end
      if (done) begin
        done_seen = 1; got_err = err; got_len = rsp_len;
        chk(!busy, "R1", "busy low at done", busy, 0);
      end
    end
  end

  task automatic make_cmd(input int len, input int field);
    for (int i = 0; i < 256; i++) cmd_mem[i] = 8'((i * 7 + 3) & 8'hFF);
    {cmd_mem[2], cmd_mem[3], cmd_mem[4], cmd_mem[5]} = 32'(field);
    cmd_len = 16'(len);
  endtask

  task automatic make_rsp(input int actual, input int field);
    for (int i = 0; i < 256; i++) begin dev_rsp[i] = 8'((i * 13 + 5) & 8'hFF); rsp_mem[i] = 8'hEE; end
    {dev_rsp[2], dev_rsp[3], dev_rsp[4], dev_rsp[5]} = 32'(field);
    dev_size = actual;
  endtask

  task automatic run(input int cap);
    int guard = 0;
    rd_ptr = 0; poll_cnt = 0; go_seen = 0; tx_sent = 0; rx_got = 0; hdr_done = 0;
    burst_ok = 0; last_burst = 0; trans_n = 0; sts_after_go = 0; done_seen = 0;
    wr_log.delete(); tx_chunks.delete(); rx_chunks.delete();
    cur_cap = cap; rsp_cap = 16'(cap);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done_seen && guard < 5000) begin @(negedge clk); #2; guard++; end
    chk(done_seen, "R1", "run completes", done_seen, 1);
    @(negedge clk); #2;
    chk(!done && !busy && !fr_req, "R1", "idle after done", done, 0);
  endtask

  task automatic defaults();
    burst_q.delete(); def_burst = 64; avail_after = 0; stuck_avail = 0; mid_bad = 0;
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    defaults();
    make_rsp(7, 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(!busy && !done && !fr_req, "R1", "reset state", busy, 0);

    // R2: size field mismatch, and too-short command
    make_cmd(10, 12); run(128);
    chk(got_err == 1, "R2", "mismatch error", got_err, 1);
    chk(trans_n == 0, "R2", "no transaction on mismatch", trans_n, 0);
    make_cmd(4, 4); run(128);
    chk(got_err == 1 && trans_n == 0, "R2", "short command error", got_err, 1);

    // Main exchange: zero burst re-read, varied bursts, polling
    defaults(); burst_q = '{0, 30, 100}; avail_after = 2;
    make_cmd(100, 100); make_rsp(80, 80); run(128);
    chk(got_err == 0, "R11", "success code", got_err, 0);
    chk(got_len == 80, "R11", "response length", got_len, 80);
    chk(tx_chunks.size() == 3 && tx_chunks[0] == 30 && tx_chunks[1] == 64 && tx_chunks[2] == 6,
        "R5", "tx chunk list", tx_chunks.size(), 3);
    chk(rx_chunks.size() == 4 && rx_chunks[0] == 6 && rx_chunks[1] == 64 && rx_chunks[2] == 9
        && rx_chunks[3] == 1, "R10", "rx chunk list", rx_chunks.size(), 4);
    chk(wr_log.size() == 3 && wr_log[0] == 32'h40, "R3", "ready write value", wr_log[0], 32'h40);
    chk(wr_log.size() == 3 && wr_log[1] == 32'h20, "R6", "go write value", wr_log[1], 32'h20);
    chk(wr_log.size() == 3 && wr_log[2] == 32'h40, "R11", "idle write value", wr_log[2], 32'h40);
    begin
      int bad = 0;
      for (int i = 0; i < 80; i++) if (rsp_mem[i] != dev_rsp[i]) bad++;
      chk(bad == 0, "R12", "response contents", bad, 0);
      chk(rsp_mem[80] == 8'hEE, "R10", "no write past last byte", rsp_mem[80], 8'hEE);
    end

    // Minimum response of 7 bytes
    defaults(); make_cmd(6, 6); make_rsp(7, 7); run(64);
    chk(got_err == 0 && got_len == 7, "R10", "seven byte response", got_len, 7);
    chk(rx_chunks.size() == 2 && rx_chunks[1] == 1, "R9", "header then last byte", rx_chunks.size(), 2);

    // R8: oversize and undersize response
    defaults(); make_cmd(8, 8); make_rsp(40, 200); run(128);
    chk(got_err == 3, "R8", "response above capacity", got_err, 3);
    defaults(); make_cmd(8, 8); make_rsp(40, 5); run(128);
    chk(got_err == 3, "R8", "response below minimum", got_err, 3);

    // R12: capacity smaller than the header
    defaults(); make_cmd(8, 8); make_rsp(20, 10); run(4);
    chk(got_err == 3, "R8", "small capacity error", got_err, 3);
    chk(rsp_mem[4] == 8'hEE && rsp_mem[5] == 8'hEE, "R12", "no write at or above capacity",
        rsp_mem[4], 8'hEE);
    chk(rsp_mem[3] == dev_rsp[3], "R12", "bytes below capacity stored", rsp_mem[3], dev_rsp[3]);

    // R7: timeout after POLL_LIMIT polls
    defaults(); avail_after = 1000; make_cmd(8, 8); make_rsp(20, 20); run(128);
    chk(got_err == 2, "R7", "timeout code", got_err, 2);
    chk(sts_after_go == PLIM, "R7", "poll count before timeout", sts_after_go, PLIM);

    // R9: data-available lost before last byte
    defaults(); mid_bad = 1; make_cmd(8, 8); make_rsp(20, 20); run(128);
    chk(got_err == 4, "R9", "mid status error", got_err, 4);
    chk(wr_log.size() == 2, "R9", "no idle write after mid error", wr_log.size(), 2);

    // R10: data-available stuck after last byte
    defaults(); stuck_avail = 1; make_cmd(8, 8); make_rsp(20, 20); run(128);
    chk(got_err == 5, "R10", "end status error", got_err, 5);

    // R13: request handshake is observed by framer model throughout; count it
    chk(!fr_req, "R13", "request low when idle", fr_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule